// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block sequences the two gate commands of a synchronous buck power stage from one PWM input. While enabled, the high-side command follows PWM and the low-side command takes the opposite phase. Break-before-make timing keeps the two commands from ever being high together. A disable input forces both commands low.

The turn-on of the low side after the high side drops is adaptive. The controller watches a comparator flag that reports the switch node below its low threshold. It waits until the node has been seen high and has then fallen below the threshold. If the node never rose, a shorter fixed fallback delay applies. If the node never comes down, for example when inductor current is negative and flows through the high-side body diode, a timeout forces the low side on. The low-to-high transition uses one fixed delay. All delays are parameters counted in clock cycles. The comparator flag is asynchronous and passes through a synchronizer before it is used.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: `hs_cmd` and `ls_cmd` are never high in the same cycle.
- R2: When `en` is sampled low at a clock edge, both commands are low after that edge, and they stay low while `en` stays low, whatever `pwm` and `node_low` do.
- R3: While enabled, `hs_cmd` rises only after an edge at which `pwm` was sampled high. It falls at the first edge at which `pwm` is sampled low.
- R4: When `pwm` is sampled high while `ls_cmd` is high, `ls_cmd` falls at that edge. `hs_cmd` rises `L2H_CYC` (default 3) cycles later, and this delay does not depend on `node_low`.
- R5: `node_low` (1 = switch node below threshold) passes through `SYNC_STAGES` (default 2) flops. After the high-side turn-off, once the synchronized flag has read 0 in at least one cycle, `ls_cmd` rises at the first edge at which the synchronized flag reads 1. With `node_low` rising just before edge E0+D+1, where E0 is the edge that dropped `hs_cmd`, `ls_cmd` rises at edge E0+D+3.
- R6: If the synchronized flag never reads 0 after the high-side turn-off, `ls_cmd` rises `FALLBACK_CYC` (default 15) cycles after `hs_cmd` fell.
- R7: If the node is seen high but never falls below threshold, `ls_cmd` rises `TIMEOUT_CYC` (default 19) cycles after `hs_cmd` fell.
- R8: If `pwm` is sampled high while the low-side turn-on is pending, `ls_cmd` does not assert. `hs_cmd` rises `L2H_CYC` cycles after that edge.
- R9: At the first enabled edge after a disable, a high `pwm` gives `hs_cmd` high `L2H_CYC` cycles later. A low `pwm` starts the adaptive low-side wait, so a node that never rises gives `ls_cmd` after `FALLBACK_CYC` cycles.
- R10: While `rst_n` is low, both commands are low at once and all wait counters are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| en | input | 1 | 1 = drive the stage, 0 = hold both gates off |
| pwm | input | 1 | PWM demand, 1 = high side on |
| node_low | input | 1 | Asynchronous comparator flag, 1 = switch node below threshold |
| hs_cmd | output | 1 | High-side gate command |
| ls_cmd | output | 1 | Low-side gate command |

## Verification
The bench measures the exact gap in cycles from each gate falling to the opposite gate rising. It does this for three node histories: a node that rises and then falls, a node that never rises, and a node that never falls. The three gaps must differ. A design that drops the seen-high condition would take the adaptive path when the node never rose. A design that miscounts the synchronizer or the wait counter would be off by a cycle on one of the three gaps. A pulse cancelled during the low-side wait must never show a low-side glitch, which a design that commits early to the low side would produce. Disabling the stage while either gate is on, then enabling it again at each PWM level, exposes outputs that stay latched on and a first pulse that skips its dead time.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HS_WAIT = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_LS_WAIT = 3'd3,
    ST_LS_ON   = 3'd4
  } gdc_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/gdc_sync.sv
module gdc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gdc_wait_track.sv
module gdc_wait_track #(
  parameter int CW  = 5,
  parameter int SAT = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          count_en,
  input  logic          track,
  input  logic          node_high,
  output logic [CW-1:0] cnt,
  output logic          seen_high
);

  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;
  logic          seen_q, seen_d, seen_ce;

  // Wait counter: cleared on every state change, saturates at SAT.
  always_comb begin
    cnt_ce = restart || (count_en && (cnt_q != SAT_V));
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // Sticky flag: the node was above threshold after the high side went off.
  always_comb begin
    seen_ce = restart || (track && node_high);
    seen_d  = !restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (seen_ce) seen_q <= seen_d;
  end

  assign cnt       = cnt_q;
  assign seen_high = seen_q;

endmodule

// File: rtl/gdc_fsm.sv
module gdc_fsm
  import gdc_pkg::*;
#(
  parameter int CW           = 5,
  parameter int L2H_CYC      = 3,
  parameter int FALLBACK_CYC = 15,
  parameter int TIMEOUT_CYC  = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pwm,
  input  logic          node_low_s,
  input  logic [CW-1:0] cnt,
  input  logic          seen_high,
  output gdc_state_e    state_q,
  output gdc_state_e    state_d,
  output logic          restart
);

  localparam logic [CW-1:0] L2H_LAST = CW'(L2H_CYC - 1);
  localparam logic [CW-1:0] FB_LAST  = CW'(FALLBACK_CYC - 1);
  localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT_CYC - 1);

  gdc_state_e st_q, st_d;
  logic       ls_go;

  // Low-side release: adaptive fall, fallback when the node never rose, or timeout.
  always_comb begin
    ls_go = (seen_high && node_low_s)
         || (!seen_high && node_low_s && (cnt == FB_LAST))
         || (cnt == TO_LAST);
  end

  always_comb begin
    st_d = st_q;
    if (!en) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:    st_d = pwm ? ST_HS_WAIT : ST_LS_WAIT;
        ST_HS_WAIT: begin
          if (!pwm)                  st_d = ST_LS_WAIT;
          else if (cnt == L2H_LAST)  st_d = ST_HS_ON;
        end
        ST_HS_ON:   if (!pwm) st_d = ST_LS_WAIT;
        ST_LS_WAIT: begin
          if (pwm)        st_d = ST_HS_WAIT;
          else if (ls_go) st_d = ST_LS_ON;
        end
        ST_LS_ON:   if (pwm) st_d = ST_HS_WAIT;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_q = st_q;
  assign state_d = st_d;
  assign restart = (st_d != st_q);

endmodule

// File: rtl/gate_deadtime_ctrl.sv
module gate_deadtime_ctrl
  import gdc_pkg::*;
#(
  parameter int FALLBACK_CYC = 15,
  parameter int TIMEOUT_CYC  = 19,
  parameter int L2H_CYC      = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pwm,
  input  logic node_low,
  output logic hs_cmd,
  output logic ls_cmd
);

  localparam int CNT_MAX = max3(FALLBACK_CYC, TIMEOUT_CYC, L2H_CYC);
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic          node_low_s;
  logic [CW-1:0] cnt;
  logic          seen_high;
  logic          restart;
  gdc_state_e    state_q, state_d;
  logic          hs_q, ls_q;

  gdc_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (node_low),
    .q    (node_low_s)
  );

  gdc_wait_track #(
    .CW (CW),
    .SAT(CNT_MAX)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .count_en ((state_q == ST_LS_WAIT) || (state_q == ST_HS_WAIT)),
    .track    (state_q == ST_LS_WAIT),
    .node_high(!node_low_s),
    .cnt      (cnt),
    .seen_high(seen_high)
  );

  gdc_fsm #(
    .CW          (CW),
    .L2H_CYC     (L2H_CYC),
    .FALLBACK_CYC(FALLBACK_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pwm       (pwm),
    .node_low_s(node_low_s),
    .cnt       (cnt),
    .seen_high (seen_high),
    .state_q   (state_q),
    .state_d   (state_d),
    .restart   (restart)
  );

  // Gate commands are registered from the next state so they change with it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= (state_d == ST_HS_ON);
      ls_q <= (state_d == ST_LS_ON);
    end
  end

  assign hs_cmd = hs_q;
  assign ls_cmd = ls_q;

endmodule

// File: rtl/gdc_checker.sv
module gdc_checker #(
  parameter int L2H_CYC     = 3,
  parameter int TIMEOUT_CYC = 19
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic pwm,
  input logic hs_cmd,
  input logic ls_cmd
);

  logic [15:0] ls_off_run;
  logic [15:0] pwm_low_run;

  // Cycles since the low-side command was last high (saturating).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ls_off_run <= '0;
    else if (ls_cmd)                     ls_off_run <= '0;
    else if (ls_off_run != 16'hFFFF)     ls_off_run <= ls_off_run + 16'd1;
  end

  // Edges with en high and pwm low in a row (saturating).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pwm_low_run <= '0;
    else if (!en || pwm)                 pwm_low_run <= '0;
    else if (pwm_low_run != 16'hFFFF)    pwm_low_run <= pwm_low_run + 16'd1;
  end

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_cmd && ls_cmd));

  p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_cmd && !ls_cmd));

  p_hs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_cmd) |-> ($past(pwm) && $past(en)));

  p_hs_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_cmd && !pwm) |=> !hs_cmd);

  p_l2h_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_cmd) |-> (ls_off_run >= 16'(L2H_CYC)));

  p_ls_bbm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_cmd) |-> ($past(!hs_cmd) && $past(!pwm)));

  p_ls_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_low_run > 16'(TIMEOUT_CYC)) |-> ls_cmd);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r10: assert (!hs_cmd && !ls_cmd);
    end
  end

endmodule

bind gate_deadtime_ctrl gdc_checker #(
  .L2H_CYC    (L2H_CYC),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (en),
  .pwm   (pwm),
  .hs_cmd(hs_cmd),
  .ls_cmd(ls_cmd)
);

// File: tb/gate_deadtime_ctrl_tb.sv
module gate_deadtime_ctrl_tb;

  localparam int FB  = 15;
  localparam int TO  = 19;
  localparam int L2H = 3;

  logic clk = 1'b0;
  logic rst_n, en, pwm, node_low;
  logic hs_cmd, ls_cmd;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #4 clk = ~clk;

  gate_deadtime_ctrl #(
    .FALLBACK_CYC(FB),
    .TIMEOUT_CYC (TO),
    .L2H_CYC     (L2H),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .pwm     (pwm),
    .node_low(node_low),
    .hs_cmd  (hs_cmd),
    .ls_cmd  (ls_cmd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Gap in cycles from the driving edge to the watched output rising.
  // node_low is raised after the sample at negedge number drop_at.
  task automatic wait_rise(input bit want_hs, input int drop_at, output int g);
    g = -1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (hs_cmd && ls_cmd) chk("R1 overlap", 1, 0);
      if (want_hs ? hs_cmd : ls_cmd) begin
        g = k - 1;
        break;
      end
      if (k == drop_at) node_low = 1'b1;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 hs in reset", hs_cmd, 0);
    chk("R10 ls in reset", ls_cmd, 0);
  endtask

  task automatic t_start_low();
    int g;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 hs while disabled", hs_cmd, 0);
    en = 1'b1; pwm = 1'b0; node_low = 1'b1;
    wait_rise(1'b0, -1, g);
    chk("R9 R6 start low gap", g, FB);
  endtask

  task automatic t_hs_on(input string tag);
    int g;
    pwm = 1'b1;
    @(negedge clk);
    chk({tag, " ls off at pwm edge"}, ls_cmd, 0);
    chk({tag, " hs held in dead time"}, hs_cmd, 0);
    wait_rise(1'b1, -1, g);
    chk({tag, " low-to-high gap"}, g + 1, L2H);
  endtask

  task automatic t_fallback();
    int g;
    node_low = 1'b1;
    repeat (3) @(negedge clk);
    pwm = 1'b0;
    @(negedge clk);
    chk("R3 hs falls with pwm", hs_cmd, 0);
    wait_rise(1'b0, -1, g);
    chk("R6 fallback gap", g + 1, FB);
  endtask

  task automatic t_adaptive();
    int g;
    node_low = 1'b0;
    repeat (4) @(negedge clk);
    pwm = 1'b0;
    wait_rise(1'b0, 5, g);
    chk("R5 adaptive gap", g, 7);
  endtask

  task automatic t_timeout();
    int g;
    node_low = 1'b0;
    repeat (4) @(negedge clk);
    pwm = 1'b0;
    wait_rise(1'b0, -1, g);
    chk("R7 timeout gap", g, TO);
  endtask

  task automatic t_cancel();
    int g;
    int ls_seen = 0;
    node_low = 1'b1;
    repeat (3) @(negedge clk);
    pwm = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (ls_cmd) ls_seen++;
    end
    pwm = 1'b1;
    wait_rise(1'b1, -1, g);
    if (ls_cmd) ls_seen++;
    chk("R8 no ls pulse on cancel", ls_seen, 0);
    chk("R8 hs gap after cancel", g, L2H);
  endtask

  task automatic t_disable();
    int hi = 0;
    en = 1'b0;
    @(negedge clk);
    chk("R2 hs off next edge", hs_cmd, 0);
    chk("R2 ls off next edge", ls_cmd, 0);
    for (int k = 0; k < 8; k++) begin
      pwm = k[0];
      node_low = k[1];
      @(negedge clk);
      if (hs_cmd || ls_cmd) hi++;
    end
    chk("R2 held low while disabled", hi, 0);
  endtask

  task automatic t_reenable_high();
    int g;
    pwm = 1'b1;
    @(negedge clk);
    en = 1'b1;
    wait_rise(1'b1, -1, g);
    chk("R9 re-enable high gap", g, L2H);
  endtask

  task automatic t_reenable_low_then_off();
    int g;
    pwm = 1'b0; node_low = 1'b1;
    @(negedge clk);
    en = 1'b1;
    wait_rise(1'b0, -1, g);
    chk("R9 re-enable low gap", g, FB);
    en = 1'b0;
    @(negedge clk);
    chk("R2 ls off on disable", ls_cmd, 0);
    en = 1'b1;
    repeat (FB + 2) @(negedge clk);
    chk("R6 ls back after re-enable", ls_cmd, 1);
    #1 rst_n = 1'b0;
    #1;
    chk("R10 ls cleared by reset", ls_cmd, 0);
    chk("R10 hs cleared by reset", hs_cmd, 0);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; pwm = 1'b0; node_low = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_start_low();
    t_hs_on("R4");
    t_fallback();
    t_hs_on("R4 R3");
    t_adaptive();
    t_hs_on("R4");
    t_timeout();
    t_hs_on("R4");
    t_cancel();
    t_disable();
    t_reenable_high();
    en = 1'b0;
    @(negedge clk);
    chk("R2 hs off on disable", hs_cmd, 0);
    t_reenable_low_then_off();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule